// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Sequencer

This block sits on the controller side of an SDRAM interface. It owns the clock-enable pin and, during low-power transitions, the four command strobes. The main controller raises a level request for one of three low-power modes: power down, self refresh or clock suspend. Along with the request it reports whether every bank is idle and whether a read or write burst is running. The sequencer chooses the mode from the request and its precondition. It then lowers clock-enable, and on that same edge it drives the command that selects the mode.

Each mode is left in its own way. Power down and clock suspend end with a single high clock-enable cycle carrying a NOP, and the device can accept commands on the following edge. Self refresh ends with a run of NOPs at clock-enable high. This run covers the exit window and is never shorter than two cycles. A ready flag tells the main controller when it may issue normal commands again. Whenever ready is high, the sequencer's own strobes rest at NOP, so the main controller can multiplex its commands onto the bus.

Top module: `sdram_lp_seq`

## Requirements
- R1: A synchronous active-high reset gives cke=1, a NOP on the strobes (cs_n=0, ras_n=1, cas_n=1, we_n=1) and ready=0. On the first clock edge after reset is released, ready rises to 1 with cke=1 and NOP.
- R2: While ready is high, a power-down request with banks_idle high makes the next edge drive cke=0 with NOP and ready=0.
- R3: While ready is high, a self-refresh request with banks_idle high makes the next edge drive cke=0 with AUTO REFRESH (cs_n=0, ras_n=0, cas_n=0, we_n=1) for exactly one cycle. NOP with cke=0 follows.
- R4: While ready is high, a clock-suspend request with burst_busy high makes the next edge drive cke=0 with NOP and ready=0.
- R5: When more than one request is eligible on the same edge, self refresh wins over power down, and power down wins over clock suspend.
- R6: A request whose precondition is false is held off. Clock-enable stays high, NOP is driven and ready is 0. Entry happens on the first edge where the precondition holds. If every request drops first, ready returns to 1 on the next edge.
- R7: While in a low-power mode, cke stays 0, the strobes stay at NOP and ready stays 0, whatever the requests, banks_idle or burst_busy do, until wake is seen.
- R8: wake in power down or clock suspend gives one cycle of cke=1, NOP and ready=0, then ready=1.
- R9: wake in self refresh gives max(TXSR,2) cycles of cke=1, NOP and ready=0, then ready=1.
- R10: wake while ready is high and no request is pending has no effect: cke, the strobes and ready stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pd | input | 1 | Power-down request (level) |
| req_sr | input | 1 | Self-refresh request (level) |
| req_susp | input | 1 | Clock-suspend request (level) |
| wake | input | 1 | Leave the current low-power mode |
| banks_idle | input | 1 | All banks precharged and idle |
| burst_busy | input | 1 | A read or write burst is in progress |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | Main controller may issue commands |

## Verification
The bench aims first at the self-refresh exit window. It runs two instances, one with a long window and one with a window shorter than two cycles. A design that skipped the two-NOP floor would raise ready after one cycle, and a design that counted one cycle off would end the window early or late. The second target is a request that arrives without its precondition. A sequencer that ignored the precondition would drop clock-enable with banks still open. A sequencer that got stuck would never return ready once the request fell. The third target is a burst of request, precondition and wake changes while the block is already in a low-power mode. A design that reacted to them would leave the mode, or put something other than NOP on the bus, while clock-enable is low.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_RUN,
    ST_HOLD,
    ST_SR_ENT,
    ST_SR,
    ST_PD,
    ST_SUSP,
    ST_WAKE,
    ST_SRX
  } lp_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // Length of the self-refresh exit window: never below two NOP cycles.
  function automatic int xsr_len(input int txsr);
    return (txsr < 2) ? 2 : txsr;
  endfunction

  function automatic logic is_nop(input sd_cmd_t c);
    return !c.cs_n && c.ras_n && c.cas_n && c.we_n;
  endfunction

  function automatic logic is_aref(input sd_cmd_t c);
    return !c.cs_n && !c.ras_n && !c.cas_n && c.we_n;
  endfunction

endpackage

// File: rtl/lp_entry_arb.sv
module lp_entry_arb (
  input  logic req_pd,
  input  logic req_sr,
  input  logic req_susp,
  input  logic banks_idle,
  input  logic burst_busy,
  output logic any_req,
  output logic go_sr,
  output logic go_pd,
  output logic go_susp
);
  logic ok_sr, ok_pd, ok_susp;

  // Precondition per mode
  assign ok_sr   = req_sr   && banks_idle;
  assign ok_pd   = req_pd   && banks_idle;
  assign ok_susp = req_susp && burst_busy;

  // Fixed priority: self refresh, then power down, then clock suspend
  assign go_sr   = ok_sr;
  assign go_pd   = ok_pd && !ok_sr;
  assign go_susp = ok_susp && !ok_sr && !ok_pd;
  assign any_req = req_pd || req_sr || req_susp;
endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lp_pin_drv.sv
module lp_pin_drv
  import sdram_lp_pkg::*;
(
  input  lp_state_e st,
  output logic      cke,
  output sd_cmd_t   cmd,
  output logic      ready
);
  always_comb begin
    cke   = 1'b1;
    cmd   = CMD_NOP;
    ready = 1'b0;
    unique case (st)
      ST_RUN:                cke = 1'b1;
      ST_SR_ENT: begin
        cke = 1'b0;
        cmd = CMD_AREF;
      end
      ST_SR, ST_PD, ST_SUSP: cke = 1'b0;
      default:               cke = 1'b1;
    endcase
    ready = (st == ST_RUN);
  end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int TXSR = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic req_pd,
  input  logic req_sr,
  input  logic req_susp,
  input  logic wake,
  input  logic banks_idle,
  input  logic burst_busy,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int XSR_LEN = xsr_len(TXSR);

  lp_state_e st_q, st_d;
  logic any_req, go_sr, go_pd, go_susp;
  logic tmr_load, tmr_done;
  sd_cmd_t cmd;

  // Named internal events
  logic accepting, entry_fire, sr_exiting, wake_seen;

  lp_entry_arb arb_i (
    .req_pd    (req_pd),
    .req_sr    (req_sr),
    .req_susp  (req_susp),
    .banks_idle(banks_idle),
    .burst_busy(burst_busy),
    .any_req   (any_req),
    .go_sr     (go_sr),
    .go_pd     (go_pd),
    .go_susp   (go_susp)
  );

  assign accepting  = (st_q == ST_RUN) || (st_q == ST_HOLD);
  assign entry_fire = accepting && (go_sr || go_pd || go_susp);
  assign sr_exiting = (st_q == ST_SRX);
  assign wake_seen  = wake && ((st_q == ST_SR) || (st_q == ST_PD) || (st_q == ST_SUSP));
  assign tmr_load   = wake && (st_q == ST_SR);

  lp_exit_timer #(.LEN(XSR_LEN)) tmr_i (
    .clk (clk),
    .rst (rst),
    .load(tmr_load),
    .run (sr_exiting),
    .done(tmr_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INIT: st_d = ST_RUN;
      ST_RUN, ST_HOLD: begin
        if (go_sr)        st_d = ST_SR_ENT;
        else if (go_pd)   st_d = ST_PD;
        else if (go_susp) st_d = ST_SUSP;
        else if (any_req) st_d = ST_HOLD;
        else              st_d = ST_RUN;
      end
      ST_SR_ENT: st_d = ST_SR;
      ST_SR:     if (wake_seen) st_d = ST_SRX;
      ST_PD,
      ST_SUSP:   if (wake_seen) st_d = ST_WAKE;
      ST_WAKE:   st_d = ST_RUN;
      ST_SRX:    if (tmr_done) st_d = ST_RUN;
      default:   st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_INIT;
    else     st_q <= st_d;
  end

  lp_pin_drv drv_i (
    .st   (st_q),
    .cke  (cke),
    .cmd  (cmd),
    .ready(ready)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk
  import sdram_lp_pkg::*;
#(
  parameter int TXSR = 5
) (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready,
  input logic banks_idle,
  input logic burst_busy,
  input logic sr_exiting
);
  localparam int XSR_N = xsr_len(TXSR);

  sd_cmd_t c;
  logic nop, aref;
  logic [31:0] nop_run;

  assign c    = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
  assign nop  = is_nop(c);
  assign aref = is_aref(c);

  // Consecutive cycles of clock-enable high, NOP and ready low
  always_ff @(posedge clk) begin
    if (rst || !cke || ready) nop_run <= '0;
    else if (nop && nop_run != 32'hFFFF_FFFF) nop_run <= nop_run + 1'b1;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) rst |=> (cke && nop && !ready));

  // R3
  sr_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cke) && aref) |-> $past(banks_idle));

  // R3
  aref_once_chk: assert property (@(posedge clk) disable iff (rst)
    aref |-> ($fell(cke) && !ready));

  // R2 R4
  quiet_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cke) && nop) |-> ($past(banks_idle) || $past(burst_busy)));

  // R7
  lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cke && $past(!cke)) |-> (nop && !ready));

  // R8
  wake_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (nop && !ready));

  // R9
  xsr_window_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && $past(sr_exiting)) |-> (nop_run >= 32'(XSR_N)));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cke && nop));
endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.TXSR(TXSR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ready     (ready),
  .banks_idle(banks_idle),
  .burst_busy(burst_busy),
  .sr_exiting(sr_exiting)
);

// File: tb/sdram_lp_seq_tb.sv
module sdram_lp_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TXSR_A = 5;
  localparam int TXSR_B = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_pd = 0, req_sr = 0, req_susp = 0, wake = 0, banks_idle = 0, burst_busy = 0;
  logic a_cke, a_cs, a_ras, a_cas, a_we, a_rdy;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_rdy;

  always #2 clk = ~clk;

  sdram_lp_seq #(.TXSR(TXSR_A)) dut_i (
    .clk(clk), .rst(rst), .req_pd(req_pd), .req_sr(req_sr), .req_susp(req_susp),
    .wake(wake), .banks_idle(banks_idle), .burst_busy(burst_busy),
    .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .ready(a_rdy));

  sdram_lp_seq #(.TXSR(TXSR_B)) dut_b (
    .clk(clk), .rst(rst), .req_pd(req_pd), .req_sr(req_sr), .req_susp(req_susp),
    .wake(wake), .banks_idle(banks_idle), .burst_busy(burst_busy),
    .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .ready(b_rdy));

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // Reference model, modes: 0 reset,1 ready,2 held,3 sr-entry,4 sr,5 pd,6 susp,7 one-cycle exit,8 sr exit
  int m_mode = 0;
  int m_left = 0;

  function automatic int win(input int t);
    if (t >= 2) return t;
    return 2;
  endfunction

  // {cke, cs_n, ras_n, cas_n, we_n, ready}
  function automatic logic [5:0] pins_for(input int mode);
    if (mode == 1) return 6'b1_0111_1;
    if (mode == 3) return 6'b0_0001_0;
    if (mode == 4 || mode == 5 || mode == 6) return 6'b0_0111_0;
    return 6'b1_0111_0;
  endfunction

  task automatic model_step();
    logic e_sr, e_pd, e_su;
    e_sr = req_sr && banks_idle;
    e_pd = req_pd && banks_idle && !e_sr;
    e_su = req_susp && burst_busy && !e_sr && !e_pd;
    if (rst) begin
      m_mode = 0;
    end else if (m_mode == 0 || m_mode == 7) begin
      m_mode = 1;
    end else if (m_mode == 1 || m_mode == 2) begin
      if (e_sr) m_mode = 3;
      else if (e_pd) m_mode = 5;
      else if (e_su) m_mode = 6;
      else m_mode = (req_pd || req_sr || req_susp) ? 2 : 1;
    end else if (m_mode == 3) begin
      m_mode = 4;
    end else if (m_mode == 4) begin
      if (wake) begin m_mode = 8; m_left = win(TXSR_A); end
    end else if (m_mode == 5 || m_mode == 6) begin
      if (wake) m_mode = 7;
    end else if (m_mode == 8) begin
      m_left = m_left - 1;
      if (m_left == 0) m_mode = 1;
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [5:0] got;
    @(posedge clk);
    model_step();
    #1;
    got = {a_cke, a_cs, a_ras, a_cas, a_we, a_rdy};
    check_eq(tag, int'(got), int'(pins_for(m_mode)));
  endtask

  task automatic set_in(input logic pd, input logic sr, input logic su,
                        input logic wk, input logic idle, input logic busy);
    req_pd = pd; req_sr = sr; req_susp = su; wake = wk; banks_idle = idle; burst_busy = busy;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int na, nb;
    // R1 reset state and first ready
    tag = "R1";
    tick(); tick();
    rst = 0;
    tick(); tick();

    // R10 wake with nothing pending
    tag = "R10";
    set_in(0, 0, 0, 1, 1, 0); tick(); tick();

    // R2 power down, R7 ignore inside, R8 exit
    tag = "R2";
    set_in(1, 0, 0, 0, 1, 0); tick();
    tag = "R7";
    set_in(1, 1, 1, 0, 1, 1); tick(); tick();
    set_in(0, 0, 0, 0, 0, 0); tick();
    tag = "R8";
    set_in(0, 0, 0, 1, 0, 0); tick();
    set_in(0, 0, 0, 0, 0, 0); tick(); tick();

    // R6 held off, then released by precondition
    tag = "R6";
    set_in(1, 0, 0, 0, 0, 0); tick(); tick(); tick();
    set_in(1, 0, 0, 0, 1, 0); tick();
    set_in(0, 0, 0, 1, 0, 0); tick();
    set_in(0, 0, 0, 0, 0, 0); tick(); tick();
    // R6 held off, then dropped
    set_in(0, 0, 1, 0, 1, 0); tick(); tick();
    set_in(0, 0, 0, 0, 1, 0); tick(); tick();

    // R4 clock suspend and one-cycle exit
    tag = "R4";
    set_in(0, 0, 1, 0, 0, 1); tick(); tick();
    tag = "R8";
    set_in(0, 0, 0, 1, 0, 1); tick();
    set_in(0, 0, 0, 0, 0, 0); tick(); tick();

    // R5 priority: all eligible picks self refresh, then pd over susp
    tag = "R5";
    set_in(1, 1, 1, 0, 1, 1); tick(); tick();
    set_in(0, 0, 0, 1, 0, 0); tick();
    set_in(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) tick();
    set_in(1, 0, 1, 0, 1, 1); tick(); tick();
    set_in(0, 0, 0, 1, 0, 0); tick();
    set_in(0, 0, 0, 0, 0, 0); tick(); tick();

    // R3 self-refresh entry and R9 exit windows on both instances
    tag = "R3";
    set_in(0, 1, 0, 0, 1, 0); tick();
    set_in(0, 0, 0, 0, 1, 0); tick(); tick();
    tag = "R9";
    set_in(0, 0, 0, 1, 0, 0); tick();
    set_in(0, 0, 0, 0, 0, 0);
    na = 0; nb = 0;
    for (int i = 0; i < 12; i++) begin
      if (a_cke && !a_rdy) na++;
      if (b_cke && !b_rdy) nb++;
      tick();
    end
    check_eq("R9", na, win(TXSR_A));
    check_eq("R9", nb, 2);
    check_eq("R9", int'({b_cke, b_rdy}), 3);

    // Random stimulus mixed with the model
    tag = "RND";
    void'($urandom(32'h5D1E_0A7B));
    for (int i = 0; i < 4000; i++) begin
      set_in(($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 5) == 0,
             ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0);
      tick();
    end

    // R1 reset from mid-operation
    tag = "R1";
    set_in(0, 0, 1, 0, 0, 1);
    rst = 1; tick();
    rst = 0; set_in(0, 0, 0, 0, 0, 0); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule